// File: doc/BRIEF.md
# Speculative Load Value Synonym Store

This block carries speculative load values between instructions that a dependence predictor has tied together under a shared synonym. Either a store or a load can be the producer. When a predicted producer is dispatched, it claims a synonym. Its destination physical register is recorded against that synonym in a small rename table, and an entry in a set-associative value file is reserved and left empty. When the producer's memory access returns, the value is written into the entry and the entry becomes full. When the producer commits, its rename mapping is removed. The removal happens only if the mapping still names that producer's register.

A predicted consumer presents its synonym. The rename table and the value file are probed in the same cycle. If a producer with that synonym is still in flight, the consumer gets the producer's physical register tag, so it can link to the producer directly. If not, and the value file holds a full entry for that synonym, the consumer gets the stored value. In every other case the response is invalid and the consumer does not speculate. When the consumer's own memory access completes, the block compares the actual value with the speculative one. It flags a misspeculation only if the consumer had really used the speculative value.

Top module: `synfile_rename`

## Requirements
- R1: After reset, every rename mapping and every value-file entry is invalid. Until the next producer allocation, consumer lookups return `consRespValid`=0 and `misspecValid`=0.
- R2: After `prodAllocValid` with synonym S and register P, a lookup of S returns valid with `consRespIsTag`=1 and `consRespData` equal to P zero-extended. This holds until the mapping is cleared or displaced.
- R3: After S is filled with value V and its producer has committed, a lookup of S returns valid with `consRespIsTag`=0 and `consRespData`=V.
- R4: A lookup of a synonym whose file entry is empty and which has no rename mapping returns `consRespValid`=0.
- R5: A rename-table hit takes precedence over a full file entry for the same synonym.
- R6: `prodCommitValid` for S and P clears the rename mapping only if the mapping is for S and holds P. A mapping written by a younger producer of S survives the commit of an older one.
- R7: Allocating a synonym that is already present in the value file reuses that entry and marks it empty again.
- R8: A fill whose synonym is not present in the value file changes no state.
- R9: A synonym selects a value-file set from its low 9 bits, with 2 ways per set. Allocation picks, in this order: the way already holding S, then the lowest-numbered invalid way, then the set's round-robin victim way. The victim pointer starts at way 0 and advances only when the victim way is replaced.
- R10: The rename table is direct-mapped on the synonym's low 6 bits. An allocation displaces a mapping held by another synonym with the same low bits, and lookups of the displaced synonym then fall back to the value file.
- R11: The cycle after `verValid`, `misspecValid`=1. `misspecFlag` is 1 exactly when `verUsed` was 1 and `verSpecData` differed from `verActualData`.
- R12: A lookup response appears on the clock edge after `consLookValid`. It reflects the state before any allocation, fill or commit presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| prodAllocValid | input | 1 | Predicted producer claims a synonym |
| prodAllocSyn | input | 12 | Synonym claimed by the producer |
| prodAllocPreg | input | 7 | Producer destination physical register |
| prodFillValid | input | 1 | Producer memory access returned a value |
| prodFillSyn | input | 12 | Synonym of the filling producer |
| prodFillData | input | 32 | Value read by the producer |
| prodCommitValid | input | 1 | Producer commits |
| prodCommitSyn | input | 12 | Synonym of the committing producer |
| prodCommitPreg | input | 7 | Register of the committing producer |
| consLookValid | input | 1 | Predicted consumer lookup |
| consLookSyn | input | 12 | Synonym looked up |
| consRespValid | output | 1 | Lookup produced a tag or a value |
| consRespIsTag | output | 1 | 1: data holds a register tag; 0: data holds a value |
| consRespData | output | 32 | Register tag (zero-extended) or speculative value |
| verValid | input | 1 | Consumer memory access completed |
| verUsed | input | 1 | Consumer used the speculative value |
| verSpecData | input | 32 | Speculative value given to the consumer |
| verActualData | input | 32 | Value actually read from memory |
| misspecValid | output | 1 | Verification result valid |
| misspecFlag | output | 1 | Value misspeculation detected |

## Verification
The hardest states to reach from the ports are a fully occupied set and a rename index shared by two in-flight producers. In the first, allocation must evict through the round-robin pointer rather than take a free way. In the second, a displaced producer's consumers must silently fall back to stored values. The stimulus fills one set with four synonyms that differ only in their upper bits, so the victim pointer is walked twice. It also leaves one producer uncommitted while another producer with the same low six bits allocates. A further directed step presents a lookup and an allocation of the same synonym in one cycle, to show that the response reflects the earlier state.

// File: rtl/synfile_pkg.sv
package synfile_pkg;
  parameter int SYN_W      = 12;
  parameter int SF_SETS    = 512;
  parameter int SF_WAYS    = 2;
  parameter int DATA_W     = 32;
  parameter int PREG_W     = 7;
  parameter int RT_ENTRIES = 64;

  localparam int SET_W    = $clog2(SF_SETS);
  localparam int STAG_W   = SYN_W - SET_W;
  localparam int WAY_W    = (SF_WAYS > 1) ? $clog2(SF_WAYS) : 1;
  localparam int RT_IDX_W = $clog2(RT_ENTRIES);
  localparam int RT_TAG_W = SYN_W - RT_IDX_W;
  localparam int RESP_W   = (DATA_W > PREG_W) ? DATA_W : PREG_W;

  typedef struct packed {
    logic             allocEn;
    logic [WAY_W-1:0] allocWay;
    logic             allocAdvance;
    logic             fillEn;
    logic [WAY_W-1:0] fillWay;
    logic             rtClear;
    logic             lookFileHit;
    logic [WAY_W-1:0] lookWay;
  } sfStrobes_t;
endpackage

// File: rtl/synfile_ctrl.sv
module synfile_ctrl
  import synfile_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic               fillValid,
  input  logic               commitValid,
  input  logic [SF_WAYS-1:0] allocMatch,
  input  logic [SF_WAYS-1:0] allocFree,
  input  logic [WAY_W-1:0]   allocVictim,
  input  logic [SF_WAYS-1:0] fillMatch,
  input  logic [SF_WAYS-1:0] lookMatch,
  input  logic [SF_WAYS-1:0] lookFull,
  input  logic               commitMatch,
  output sfStrobes_t         st
);
  logic [WAY_W-1:0] hitWay, freeWay, fillWay, lookWay;
  logic allocHit, anyFree;

  // lowest-numbered way wins each priority pick
  always_comb begin
    hitWay  = '0;
    freeWay = '0;
    fillWay = '0;
    lookWay = '0;
    for (int w = SF_WAYS - 1; w >= 0; w--) begin
      if (allocMatch[w]) hitWay  = WAY_W'(w);
      if (allocFree[w])  freeWay = WAY_W'(w);
      if (fillMatch[w])  fillWay = WAY_W'(w);
      if (lookMatch[w])  lookWay = WAY_W'(w);
    end
  end

  assign allocHit = |allocMatch;
  assign anyFree  = |allocFree;

  always_comb begin
    st              = '0;
    st.allocEn      = allocValid;
    st.allocWay     = allocHit ? hitWay : (anyFree ? freeWay : allocVictim);
    st.allocAdvance = allocValid && !allocHit && !anyFree;
    st.fillEn       = fillValid && (|fillMatch);
    st.fillWay      = fillWay;
    st.rtClear      = commitValid && commitMatch;
    st.lookFileHit  = |(lookMatch & lookFull);
    st.lookWay      = lookWay;
  end

  // R9: a synonym never occupies two ways of its set
  a_r9_alloc_unique: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allocMatch));
  a_r9_look_unique: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch));
  a_r8_fill_unique: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fillMatch));
endmodule

// File: rtl/synfile_dpath.sv
module synfile_dpath
  import synfile_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [SYN_W-1:0]   allocSyn,
  input  logic [PREG_W-1:0]  allocPreg,
  input  logic [SYN_W-1:0]   fillSyn,
  input  logic [DATA_W-1:0]  fillData,
  input  logic [SYN_W-1:0]   commitSyn,
  input  logic [PREG_W-1:0]  commitPreg,
  input  logic               lookValid,
  input  logic [SYN_W-1:0]   lookSyn,
  input  logic               verValid,
  input  logic               verUsed,
  input  logic [DATA_W-1:0]  verSpec,
  input  logic [DATA_W-1:0]  verActual,
  input  sfStrobes_t         st,
  output logic [SF_WAYS-1:0] allocMatch,
  output logic [SF_WAYS-1:0] allocFree,
  output logic [WAY_W-1:0]   allocVictim,
  output logic [SF_WAYS-1:0] fillMatch,
  output logic [SF_WAYS-1:0] lookMatch,
  output logic [SF_WAYS-1:0] lookFull,
  output logic               commitMatch,
  output logic               respValid,
  output logic               respIsTag,
  output logic [RESP_W-1:0]  respData,
  output logic               misValid,
  output logic               misFlag
);
  logic              sfValid  [SF_SETS][SF_WAYS];
  logic              sfFull   [SF_SETS][SF_WAYS];
  logic [STAG_W-1:0] sfTag    [SF_SETS][SF_WAYS];
  logic [DATA_W-1:0] sfData   [SF_SETS][SF_WAYS];
  logic [WAY_W-1:0]  sfVictim [SF_SETS];
  logic                rtValid [RT_ENTRIES];
  logic [RT_TAG_W-1:0] rtTag   [RT_ENTRIES];
  logic [PREG_W-1:0]   rtPreg  [RT_ENTRIES];

  logic [SET_W-1:0]    allocSet, fillSet, lookSet;
  logic [STAG_W-1:0]   allocTagF, fillTagF, lookTagF;
  logic [RT_IDX_W-1:0] aIdx, cIdx, lIdx;
  logic                rtLookHit;
  logic [WAY_W-1:0]    nextVictim;

  assign allocSet  = allocSyn[SET_W-1:0];
  assign fillSet   = fillSyn[SET_W-1:0];
  assign lookSet   = lookSyn[SET_W-1:0];
  assign allocTagF = allocSyn[SYN_W-1:SET_W];
  assign fillTagF  = fillSyn[SYN_W-1:SET_W];
  assign lookTagF  = lookSyn[SYN_W-1:SET_W];
  assign aIdx      = allocSyn[RT_IDX_W-1:0];
  assign cIdx      = commitSyn[RT_IDX_W-1:0];
  assign lIdx      = lookSyn[RT_IDX_W-1:0];

  for (genvar w = 0; w < SF_WAYS; w++) begin : g_way
    assign allocMatch[w] = sfValid[allocSet][w] && (sfTag[allocSet][w] == allocTagF);
    assign allocFree[w]  = !sfValid[allocSet][w];
    assign fillMatch[w]  = sfValid[fillSet][w] && (sfTag[fillSet][w] == fillTagF);
    assign lookMatch[w]  = sfValid[lookSet][w] && (sfTag[lookSet][w] == lookTagF);
    assign lookFull[w]   = sfFull[lookSet][w];
  end

  assign allocVictim = sfVictim[allocSet];
  assign nextVictim  = (allocVictim == WAY_W'(SF_WAYS - 1)) ? '0 : allocVictim + 1'b1;
  assign rtLookHit   = rtValid[lIdx] && (rtTag[lIdx] == lookSyn[SYN_W-1:RT_IDX_W]);
  assign commitMatch = rtValid[cIdx] && (rtTag[cIdx] == commitSyn[SYN_W-1:RT_IDX_W])
                       && (rtPreg[cIdx] == commitPreg);

  // control state; allocation written after fill so it wins on a collision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SF_SETS; s++) begin
        sfVictim[s] <= '0;
        for (int w = 0; w < SF_WAYS; w++) begin
          sfValid[s][w] <= 1'b0;
          sfFull[s][w]  <= 1'b0;
        end
      end
      for (int r = 0; r < RT_ENTRIES; r++) rtValid[r] <= 1'b0;
    end else begin
      if (st.fillEn) sfFull[fillSet][st.fillWay] <= 1'b1;
      if (st.allocEn) begin
        sfValid[allocSet][st.allocWay] <= 1'b1;
        sfFull[allocSet][st.allocWay]  <= 1'b0;
      end
      if (st.allocAdvance) sfVictim[allocSet] <= nextVictim;
      if (st.rtClear) rtValid[cIdx] <= 1'b0;
      if (allocValid) rtValid[aIdx] <= 1'b1;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (st.fillEn) sfData[fillSet][st.fillWay] <= fillData;
    if (st.allocEn) sfTag[allocSet][st.allocWay] <= allocTagF;
    if (allocValid) begin
      rtTag[aIdx]  <= allocSyn[SYN_W-1:RT_IDX_W];
      rtPreg[aIdx] <= allocPreg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respIsTag <= 1'b0;
      respData  <= '0;
      misValid  <= 1'b0;
      misFlag   <= 1'b0;
    end else begin
      respValid <= lookValid && (rtLookHit || st.lookFileHit);
      respIsTag <= lookValid && rtLookHit;
      respData  <= rtLookHit ? RESP_W'(rtPreg[lIdx]) : RESP_W'(sfData[lookSet][st.lookWay]);
      misValid  <= verValid;
      misFlag   <= verValid && verUsed && (verSpec != verActual);
    end
  end

  // R12: a response only follows a lookup in the previous cycle
  a_r12_resp_follows_look: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(lookValid));
  // R11: misspeculation requires the value to have been used
  a_r11_flag_needs_use: assert property (@(posedge clk) disable iff (!rstN)
    misFlag |-> (misValid && $past(verUsed)));
  // R2: a tag response is always valid
  a_r2_tag_is_valid: assert property (@(posedge clk) disable iff (!rstN)
    respIsTag |-> respValid);
endmodule

// File: rtl/synfile_rename.sv
module synfile_rename
  import synfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              prodAllocValid,
  input  logic [SYN_W-1:0]  prodAllocSyn,
  input  logic [PREG_W-1:0] prodAllocPreg,
  input  logic              prodFillValid,
  input  logic [SYN_W-1:0]  prodFillSyn,
  input  logic [DATA_W-1:0] prodFillData,
  input  logic              prodCommitValid,
  input  logic [SYN_W-1:0]  prodCommitSyn,
  input  logic [PREG_W-1:0] prodCommitPreg,
  input  logic              consLookValid,
  input  logic [SYN_W-1:0]  consLookSyn,
  output logic              consRespValid,
  output logic              consRespIsTag,
  output logic [RESP_W-1:0] consRespData,
  input  logic              verValid,
  input  logic              verUsed,
  input  logic [DATA_W-1:0] verSpecData,
  input  logic [DATA_W-1:0] verActualData,
  output logic              misspecValid,
  output logic              misspecFlag
);
  sfStrobes_t         st;
  logic [SF_WAYS-1:0] allocMatch, allocFree, fillMatch, lookMatch, lookFull;
  logic [WAY_W-1:0]   allocVictim;
  logic               commitMatch;

  synfile_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(prodAllocValid), .fillValid(prodFillValid), .commitValid(prodCommitValid),
    .allocMatch(allocMatch), .allocFree(allocFree), .allocVictim(allocVictim),
    .fillMatch(fillMatch), .lookMatch(lookMatch), .lookFull(lookFull),
    .commitMatch(commitMatch), .st(st)
  );

  synfile_dpath u_dpath (
    .clk(clk), .rstN(rstN),
    .allocValid(prodAllocValid), .allocSyn(prodAllocSyn), .allocPreg(prodAllocPreg),
    .fillSyn(prodFillSyn), .fillData(prodFillData),
    .commitSyn(prodCommitSyn), .commitPreg(prodCommitPreg),
    .lookValid(consLookValid), .lookSyn(consLookSyn),
    .verValid(verValid), .verUsed(verUsed), .verSpec(verSpecData), .verActual(verActualData),
    .st(st),
    .allocMatch(allocMatch), .allocFree(allocFree), .allocVictim(allocVictim),
    .fillMatch(fillMatch), .lookMatch(lookMatch), .lookFull(lookFull),
    .commitMatch(commitMatch),
    .respValid(consRespValid), .respIsTag(consRespIsTag), .respData(consRespData),
    .misValid(misspecValid), .misFlag(misspecFlag)
  );
endmodule

// File: tb/synfile_rename_test.sv
module synfile_rename_test;
  import synfile_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 43;
  localparam logic [2:0] OP_ALLOC = 3'd1, OP_FILL = 3'd2, OP_COMMIT = 3'd3, OP_LOOK = 3'd4;

  // {req, op, syn, preg, data, expValid, expIsTag, expData}
  localparam logic [91:0] VEC [NV] = '{
    {4'd1,  OP_LOOK,   12'h005, 7'd0,  32'h0,         1'b0, 1'b0, 32'h0},        // R1
    {4'd0,  OP_ALLOC,  12'h005, 7'd11, 32'h0,         1'b0, 1'b0, 32'h0},
    {4'd2,  OP_LOOK,   12'h005, 7'd0,  32'h0,         1'b1, 1'b1, 32'd11},       // R2
    {4'd0,  OP_FILL,   12'h005, 7'd0,  32'hA5A5_0001, 1'b0, 1'b0, 32'h0},
    {4'd5,  OP_LOOK,   12'h005, 7'd0,  32'h0,         1'b1, 1'b1, 32'd11},       // R5
    {4'd0,  OP_COMMIT, 12'h005, 7'd11, 32'h0,         1'b0, 1'b0, 32'h0},
    {4'd3,  OP_LOOK,   12'h005, 7'd0,  32'h0,         1'b1, 1'b0, 32'hA5A5_0001},// R3
    {4'd0,  OP_ALLOC,  12'h005, 7'd22, 32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_COMMIT, 12'h005, 7'd22, 32'h0,         1'b0, 1'b0, 32'h0},
    {4'd7,  OP_LOOK,   12'h005, 7'd0,  32'h0,         1'b0, 1'b0, 32'h0},        // R7
    {4'd0,  OP_ALLOC,  12'h040, 7'd3,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_ALLOC,  12'h040, 7'd4,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_COMMIT, 12'h040, 7'd3,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd6,  OP_LOOK,   12'h040, 7'd0,  32'h0,         1'b1, 1'b1, 32'd4},        // R6
    {4'd0,  OP_COMMIT, 12'h040, 7'd4,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd4,  OP_LOOK,   12'h040, 7'd0,  32'h0,         1'b0, 1'b0, 32'h0},        // R4
    {4'd0,  OP_FILL,   12'h077, 7'd0,  32'h0000_1234, 1'b0, 1'b0, 32'h0},
    {4'd8,  OP_LOOK,   12'h077, 7'd0,  32'h0,         1'b0, 1'b0, 32'h0},        // R8
    {4'd0,  OP_ALLOC,  12'h010, 7'd1,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_FILL,   12'h010, 7'd0,  32'h1111_0010, 1'b0, 1'b0, 32'h0},
    {4'd0,  OP_COMMIT, 12'h010, 7'd1,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_ALLOC,  12'h210, 7'd2,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_FILL,   12'h210, 7'd0,  32'h2222_0210, 1'b0, 1'b0, 32'h0},
    {4'd0,  OP_COMMIT, 12'h210, 7'd2,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd9,  OP_LOOK,   12'h010, 7'd0,  32'h0,         1'b1, 1'b0, 32'h1111_0010},// R9
    {4'd9,  OP_LOOK,   12'h210, 7'd0,  32'h0,         1'b1, 1'b0, 32'h2222_0210},// R9
    {4'd0,  OP_ALLOC,  12'h410, 7'd3,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_FILL,   12'h410, 7'd0,  32'h3333_0410, 1'b0, 1'b0, 32'h0},
    {4'd0,  OP_COMMIT, 12'h410, 7'd3,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd9,  OP_LOOK,   12'h010, 7'd0,  32'h0,         1'b0, 1'b0, 32'h0},        // R9 way0 evicted
    {4'd9,  OP_LOOK,   12'h210, 7'd0,  32'h0,         1'b1, 1'b0, 32'h2222_0210},// R9
    {4'd9,  OP_LOOK,   12'h410, 7'd0,  32'h0,         1'b1, 1'b0, 32'h3333_0410},// R9
    {4'd0,  OP_ALLOC,  12'h610, 7'd5,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_FILL,   12'h610, 7'd0,  32'h5555_0610, 1'b0, 1'b0, 32'h0},
    {4'd0,  OP_COMMIT, 12'h610, 7'd5,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd9,  OP_LOOK,   12'h210, 7'd0,  32'h0,         1'b0, 1'b0, 32'h0},        // R9 way1 evicted
    {4'd9,  OP_LOOK,   12'h410, 7'd0,  32'h0,         1'b1, 1'b0, 32'h3333_0410},// R9
    {4'd9,  OP_LOOK,   12'h610, 7'd0,  32'h0,         1'b1, 1'b0, 32'h5555_0610},// R9
    {4'd0,  OP_ALLOC,  12'h0C1, 7'd9,  32'h0,         1'b0, 1'b0, 32'h0},
    {4'd0,  OP_FILL,   12'h0C1, 7'd0,  32'hC1C1_0001, 1'b0, 1'b0, 32'h0},
    {4'd0,  OP_ALLOC,  12'h081, 7'd10, 32'h0,         1'b0, 1'b0, 32'h0},
    {4'd10, OP_LOOK,   12'h0C1, 7'd0,  32'h0,         1'b1, 1'b0, 32'hC1C1_0001},// R10
    {4'd10, OP_LOOK,   12'h081, 7'd0,  32'h0,         1'b1, 1'b1, 32'd10}        // R10
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic prodAllocValid, prodFillValid, prodCommitValid, consLookValid;
  logic [SYN_W-1:0] prodAllocSyn, prodFillSyn, prodCommitSyn, consLookSyn;
  logic [PREG_W-1:0] prodAllocPreg, prodCommitPreg;
  logic [DATA_W-1:0] prodFillData, verSpecData, verActualData;
  logic consRespValid, consRespIsTag, verValid, verUsed, misspecValid, misspecFlag;
  logic [RESP_W-1:0] consRespData;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synfile_rename uut (.*);

  task automatic idleAll();
    prodAllocValid = 0; prodFillValid = 0; prodCommitValid = 0; consLookValid = 0;
    prodAllocSyn = '0; prodFillSyn = '0; prodCommitSyn = '0; consLookSyn = '0;
    prodAllocPreg = '0; prodCommitPreg = '0; prodFillData = '0;
    verValid = 0; verUsed = 0; verSpecData = '0; verActualData = '0;
  endtask

  task automatic chk(input string req, input logic [RESP_W+1:0] act, input logic [RESP_W+1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic respCheck(input string req, input logic v, input logic k, input logic [RESP_W-1:0] d);
    chk(req, {consRespValid, consRespIsTag, consRespValid ? consRespData : '0},
             {v, k, v ? d : '0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idleAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the outputs
    chk("R1", {consRespValid, misspecValid, {RESP_W{1'b0}}}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [91:0] v;
      v = VEC[i];
      @(negedge clk);
      case (v[87:85])
        OP_ALLOC:  begin prodAllocValid = 1; prodAllocSyn = v[84:73]; prodAllocPreg = v[72:66]; end
        OP_FILL:   begin prodFillValid = 1; prodFillSyn = v[84:73]; prodFillData = v[65:34]; end
        OP_COMMIT: begin prodCommitValid = 1; prodCommitSyn = v[84:73]; prodCommitPreg = v[72:66]; end
        default:   begin consLookValid = 1; consLookSyn = v[84:73]; end
      endcase
      @(negedge clk);
      idleAll();
      if (v[87:85] == OP_LOOK)
        respCheck($sformatf("R%0d vector %0d", v[91:88], i), v[33], v[32], v[31:0]);
    end

    // R12: lookup sees state before a same-cycle allocation
    @(negedge clk);
    consLookValid = 1; consLookSyn = 12'h0C1;
    prodAllocValid = 1; prodAllocSyn = 12'h0C1; prodAllocPreg = 7'd12;
    @(negedge clk);
    idleAll();
    respCheck("R12 same-cycle", 1'b1, 1'b0, 32'hC1C1_0001);
    @(negedge clk);
    consLookValid = 1; consLookSyn = 12'h0C1;
    @(negedge clk);
    idleAll();
    respCheck("R12 after alloc", 1'b1, 1'b1, 32'd12);

    // R11: verification outcomes
    @(negedge clk);
    verValid = 1; verUsed = 1; verSpecData = 32'd5; verActualData = 32'd6;
    @(negedge clk);
    idleAll();
    chk("R11 used mismatch", {misspecValid, misspecFlag, {RESP_W{1'b0}}}, {2'b11, {RESP_W{1'b0}}});
    @(negedge clk);
    verValid = 1; verUsed = 0; verSpecData = 32'd5; verActualData = 32'd6;
    @(negedge clk);
    idleAll();
    chk("R11 unused mismatch", {misspecValid, misspecFlag, {RESP_W{1'b0}}}, {2'b10, {RESP_W{1'b0}}});
    @(negedge clk);
    verValid = 1; verUsed = 1; verSpecData = 32'd7; verActualData = 32'd7;
    @(negedge clk);
    idleAll();
    chk("R11 used match", {misspecValid, misspecFlag, {RESP_W{1'b0}}}, {2'b10, {RESP_W{1'b0}}});

    // R1: a reset in mid-run drops every stored value
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    consLookValid = 1; consLookSyn = 12'h410;
    @(negedge clk);
    idleAll();
    respCheck("R1 after reset", 1'b0, 1'b0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule